// File: doc/BRIEF.md
# Distributed Round-Robin Bus Ownership Tracker

Several bus agents share one request-phase signal group and there is no central arbiter. Every agent holds an identical copy of this tracker. Each copy samples the shared active-low request lines, remembers which agent was granted last, and records whether that agent still holds the bus. All copies see the same lines and start from the same reset state, so they compute the same owner in the same clock without talking to each other.

Ownership rotates fairly. On a grant, the winner is the first requesting agent found by scanning upward from the agent after the last owner, wrapping at the configured agent count. An owner keeps the bus for as long as it holds its request line asserted, even if it is not using the bus (parking). When the owner drops its line, the bus passes to the next requester in rotation, or goes idle when nobody else is asking. Each copy reports the current owner, a busy flag, and whether its own agent holds the bus.

Top module: `rr_bus_tracker`

## Requirements
- R1: While reset is high on a clock edge, the tracker goes idle (`bus_busy`=0, `i_own`=0) and `owner_id` is set to the effective agent count minus one. With four agents agent 0 therefore wins the first grant.
- R2: Suppose all agents keep requesting and each owner releases its line for one clock after it is granted. Ownership then visits the agents in ascending order and wraps from the highest agent back to 0.
- R3: A request line that goes low before clock edge k is registered at edge k. The grant shows at the outputs after edge k+1. While idle with no registered request, the tracker stays idle and `owner_id` does not change.
- R4: If the owner's registered line is high and no other registered line is low, the tracker goes idle on the next edge and `owner_id` keeps the last owner.
- R5: While the owner's registered request stays asserted, ownership and the busy state stay the same, whatever other agents request.
- R6: If the owner releases while another agent requests, ownership passes on the next edge to the next requester in rotation and `bus_busy` stays 1. Example: last owner 2 (idle), agents 0 and 3 request together, and agent 3 wins. When agent 3 releases, agent 0 becomes owner.
- R7: Request lines of agents whose index is at or above the effective agent count are ignored.
- R8: An `agent_cnt` of 0 or above `N_AGENTS` is treated as `N_AGENTS`. `owner_id` is always below the effective count.
- R9: `i_own` is 1 exactly when the tracker is busy and `owner_id` equals `my_id` (both as held after the same edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| breq_n | input | N_AGENTS | Shared request lines, bit i low = agent i requests |
| my_id | input | ID_W | Index of the agent hosting this copy |
| agent_cnt | input | CNT_W | Number of agents on the bus |
| owner_id | output | ID_W | Last granted (current) owner |
| bus_busy | output | 1 | 1 = an owner holds the bus, 0 = idle |
| i_own | output | 1 | This copy's agent holds the bus |

## Verification
The bench builds the tracker with its default of four agents. It changes `agent_cnt` across resets: 4, 2, 1 and 3, plus the out-of-range values 0 and 7. This reaches the full-count rotation, masked upper request lines, the single-agent case and count clamping with one build. `my_id` is set to different agents so that `i_own` is seen both asserted and deasserted. A long random phase with three agents drives arbitrary request patterns, which covers handoff and wrap orders that the directed scenarios do not spell out.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } own_st_t;
endpackage

// File: rtl/rrb_req_sample.sv
// Registers the shared active-low request lines as active-high flags and
// drops lines that belong to agents beyond the configured count.
module rrb_req_sample #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  breq_n,
  input  logic [CW-1:0] cnt_eff,
  output logic [N-1:0]  req_q
);
  logic [N-1:0] live;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign live[g] = (CW'(g) < cnt_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= ~breq_n & live;
  end
endmodule

// File: rtl/rrb_pick.sv
// Finds the first set request, scanning from last+1 with wrap at cnt_eff.
module rrb_pick #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int CW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  input  logic [CW-1:0] cnt_eff,
  output logic [IW-1:0] win,
  output logic          any
);
  int unsigned cnt_i;
  int unsigned start;

  always_comb begin
    cnt_i = int'(cnt_eff);
    start = int'(last) + 1;
    if (start >= cnt_i) start = 0;
  end

  always_comb begin
    int unsigned idx;
    logic found;
    found = 1'b0;
    win   = last;
    for (int i = 0; i < N; i++) begin
      idx = start + i;
      if (idx >= cnt_i) idx = idx - cnt_i;
      if (!found && (i < cnt_i) && req[IW'(idx)]) begin
        found = 1'b1;
        win   = IW'(idx);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/rrb_own_state.sv
// Holds the last-owner ID and the busy/idle state; decides grants.
module rrb_own_state
  import rrb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_q,
  input  logic [CW-1:0] cnt_eff,
  input  logic [IW-1:0] my_id,
  input  logic [IW-1:0] win,
  input  logic          any,
  output logic [IW-1:0] owner_q,
  output logic          busy_q,
  output logic          mine_q
);
  own_st_t      st_q, st_n;
  logic [IW-1:0] rot_n;
  logic          owner_holds;

  assign owner_holds = req_q[owner_q];

  always_comb begin
    st_n  = st_q;
    rot_n = owner_q;
    unique case (st_q)
      ST_IDLE: begin
        if (any) begin
          st_n  = ST_BUSY;
          rot_n = win;
        end
      end
      ST_BUSY: begin
        if (!owner_holds) begin
          if (any) rot_n = win;
          else     st_n  = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      owner_q <= IW'(cnt_eff - CW'(1));
      mine_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      owner_q <= rot_n;
      mine_q  <= (st_n == ST_BUSY) && (rot_n == my_id);
    end
  end

  assign busy_q = (st_q == ST_BUSY);
endmodule

// File: rtl/rr_bus_tracker.sv
module rr_bus_tracker #(
  parameter int N_AGENTS = 4,
  parameter int ID_W     = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1,
  parameter int CNT_W    = $clog2(N_AGENTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_AGENTS-1:0] breq_n,
  input  logic [ID_W-1:0]     my_id,
  input  logic [CNT_W-1:0]    agent_cnt,
  output logic [ID_W-1:0]     owner_id,
  output logic                bus_busy,
  output logic                i_own
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(N_AGENTS);

  logic [CNT_W-1:0]    cnt_eff;
  logic [N_AGENTS-1:0] req_q;
  logic [ID_W-1:0]     win;
  logic                any;

  assign cnt_eff = ((agent_cnt == '0) || (agent_cnt > MAX_CNT)) ? MAX_CNT : agent_cnt;

  rrb_req_sample #(.N(N_AGENTS), .CW(CNT_W)) u_sample (
    .clk(clk), .rst(rst), .breq_n(breq_n), .cnt_eff(cnt_eff), .req_q(req_q)
  );

  rrb_pick #(.N(N_AGENTS), .IW(ID_W), .CW(CNT_W)) u_pick (
    .req(req_q), .last(owner_id), .cnt_eff(cnt_eff), .win(win), .any(any)
  );

  rrb_own_state #(.N(N_AGENTS), .IW(ID_W), .CW(CNT_W)) u_state (
    .clk(clk), .rst(rst), .req_q(req_q), .cnt_eff(cnt_eff), .my_id(my_id),
    .win(win), .any(any), .owner_q(owner_id), .busy_q(bus_busy), .mine_q(i_own)
  );
endmodule

// File: rtl/rrb_checker.sv
module rrb_checker #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  req_q,
  input logic [CW-1:0] cnt_eff,
  input logic [IW-1:0] my_id,
  input logic [IW-1:0] owner_id,
  input logic          bus_busy,
  input logic          i_own
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!bus_busy && !i_own));

  p_idle_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_busy && req_q == '0) |=> (!bus_busy && $stable(owner_id)));

  p_release_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && req_q == '0) |=> (!bus_busy && $stable(owner_id)));

  p_park_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && req_q[owner_id]) |=> (bus_busy && $stable(owner_id)));

  p_handoff_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && !req_q[owner_id] && req_q != '0) |=> (bus_busy && owner_id != $past(owner_id)));

  p_owner_range_r8: assert property (@(posedge clk) disable iff (rst)
    CW'(owner_id) < cnt_eff);

  p_mine_r9: assert property (@(posedge clk) disable iff (rst)
    i_own |-> (bus_busy && owner_id == my_id));
endmodule

bind rr_bus_tracker rrb_checker #(.N(N_AGENTS), .IW(ID_W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_q(req_q), .cnt_eff(cnt_eff), .my_id(my_id),
  .owner_id(owner_id), .bus_busy(bus_busy), .i_own(i_own)
);

// File: tb/rr_bus_tracker_bench.sv
`timescale 1ns/1ps
module rr_bus_tracker_bench;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] breq_n;
  logic [1:0] my_id;
  logic [2:0] agent_cnt;
  logic [1:0] owner_id;
  logic       bus_busy;
  logic       i_own;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  rr_bus_tracker u_rr_bus_tracker (
    .clk(clk), .rst(rst), .breq_n(breq_n), .my_id(my_id), .agent_cnt(agent_cnt),
    .owner_id(owner_id), .bus_busy(bus_busy), .i_own(i_own)
  );

  // Behavioural reference: last owner, busy flag, registered request set.
  int m_rot, m_busy, m_own;
  int m_req[4];

  function automatic int eff_cnt(int c);
    return (c == 0 || c > N) ? N : c;
  endfunction

  always @(posedge clk) begin
    int ce, anyr;
    ce = eff_cnt(agent_cnt);
    cycles++;
    if (rst) begin
      m_rot = ce - 1; m_busy = 0; m_own = 0;
      foreach (m_req[i]) m_req[i] = 0;
    end else begin
      anyr = 0;
      foreach (m_req[i]) anyr += m_req[i];
      if (anyr != 0 && (m_busy == 0 || m_req[m_rot] == 0)) begin
        for (int k = 1; k <= ce; k++) begin
          int c;
          c = (m_rot + k) % ce;
          if (m_req[c] != 0) begin m_rot = c; break; end
        end
        m_busy = 1;
      end else if (m_busy == 1 && m_req[m_rot] == 0) begin
        m_busy = 0;
      end
      m_own = (m_busy == 1 && m_rot == int'(my_id)) ? 1 : 0;
      foreach (m_req[i]) m_req[i] = (!breq_n[i] && i < ce) ? 1 : 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (cycles > 0) begin
      chk("R2 owner_id vs model", int'(owner_id), m_rot);
      chk("R4 bus_busy vs model", int'(bus_busy), m_busy);
      chk("R9 i_own vs model", int'(i_own), m_own);
    end
  end

  task automatic do_reset(int c, int id);
    @(negedge clk);
    rst = 1'b1; agent_cnt = 3'(c); my_id = 2'(id); breq_n = '1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; breq_n = '1; my_id = 2'd3; agent_cnt = 3'd4;
    do_reset(4, 3);
    chk("R1 reset owner", int'(owner_id), 3);
    chk("R1 reset busy", int'(bus_busy), 0);
    chk("R1 reset i_own", int'(i_own), 0);

    breq_n[2] = 1'b0;
    @(negedge clk);
    chk("R3 not yet granted", int'(bus_busy), 0);
    @(negedge clk);
    chk("R3 granted busy", int'(bus_busy), 1);
    chk("R3 granted owner", int'(owner_id), 2);

    breq_n[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 parked owner", int'(owner_id), 2);
    chk("R5 parked busy", int'(bus_busy), 1);

    breq_n = '1;
    repeat (2) @(negedge clk);
    chk("R4 idle after release", int'(bus_busy), 0);
    chk("R4 last owner kept", int'(owner_id), 2);

    breq_n[0] = 1'b0; breq_n[3] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 agent 3 wins", int'(owner_id), 3);
    chk("R9 i_own for agent 3", int'(i_own), 1);
    breq_n[3] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 handoff to 0", int'(owner_id), 0);
    chk("R6 stays busy", int'(bus_busy), 1);
    chk("R9 i_own dropped", int'(i_own), 0);

    breq_n = '0;
    repeat (2) @(negedge clk);
    for (int n = 0; n < 5; n++) begin
      int o;
      o = int'(owner_id);
      breq_n[o] = 1'b1;
      @(negedge clk);
      breq_n[o] = 1'b0;
      @(negedge clk);
      chk("R2 rotation step", int'(owner_id), (o + 1) % 4);
    end
    breq_n = '1;
    repeat (3) @(negedge clk);

    do_reset(2, 1);
    chk("R1 two-agent reset owner", int'(owner_id), 1);
    breq_n = 4'b0011;
    repeat (3) @(negedge clk);
    chk("R7 masked lines ignored", int'(bus_busy), 0);
    breq_n[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 agent 0 granted", int'(owner_id), 0);
    breq_n = '1;

    do_reset(1, 0);
    chk("R1 one-agent reset owner", int'(owner_id), 0);
    breq_n = 4'b0000;
    repeat (2) @(negedge clk);
    chk("R9 sole agent owns", int'(i_own), 1);
    breq_n = '1;

    do_reset(0, 2);
    chk("R8 count 0 clamps", int'(owner_id), 3);
    do_reset(7, 2);
    chk("R8 count 7 clamps", int'(owner_id), 3);

    do_reset(3, 2);
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      breq_n = 4'($urandom_range(0, 15));
    end
    breq_n = '1;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule